// File: doc/BRIEF.md
# DMA Input Channel Controller

This block holds the control state for one peripheral-to-memory input channel. A peripheral signals each word with a ready pulse. The controller grants a memory-reference request for that word, tracks whether the reference is still outstanding, and ends the transfer on a disconnect pulse. It also ends the transfer by itself when the external address compare reports that the current address has reached the limit. Either ending produces a single interrupt pulse.

Parity problems on the word path are recorded in a private fault flag. They are not reported until the transfer ends, so the data flow is not disturbed. At the end of the transfer the fault is promoted into the channel-error flag, together with the normal end-of-transfer interrupt. A ready pulse that arrives while the channel is idle is parked in a held-ready latch. The latch is serviced once software activates the channel.

Top module: `dma_in_chan_ctl`

## Requirements
- R1: A parity-error pulse sets the parity-fault flag on the next edge, with no change to the channel-error flag and no interrupt pulse.
- R2: A disconnect pulse while active produces a one-cycle interrupt pulse and clears the active state on the next edge. If the parity-fault flag was already set, the channel-error flag also sets.
- R3: Clear I/O clears the parity-fault and channel-error flags, and leaves the active state unchanged whether it was set or clear.
- R4: A ready pulse while inactive sets the held-ready latch, even with the limit compare true. It raises no request, no error and no interrupt. The latch stays set until consumed or cleared by Master Clear.
- R5: The held ready is consumed on the first edge at which all of these hold: the channel is active, the compare is false, no reference is pending and no new ready arrives. Consuming it raises a one-cycle memory request and clears the latch.
- R6: While active with the limit compare true, the block produces a one-cycle interrupt pulse and drops the active state on the next edge. The channel-error flag sets if the parity-fault flag was set.
- R7: Disconnect pulses or limit compares while inactive produce no interrupt.
- R8: A ready pulse while active counts as a double ready when a reference is pending, a held ready is outstanding, or the limit compare is true. A double ready sets the channel-error flag and raises no request.
- R9: A ready pulse while active and not busy raises a one-cycle memory request and sets the reference-pending flag. A memory acknowledge clears that flag.
- R10: Master Clear (and reset) clears the active state, the held-ready latch, the pending flag and both error flags.
- R11: The flag-clear input clears the channel-error flag. A clear from flag-clear or Clear I/O overrides a simultaneous set.
- R12: An activate pulse sets the active state on the next edge. All outputs are registered and change one edge after the inputs that cause them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_ready | input | 1 | Word-ready pulse from the peripheral |
| in_disc | input | 1 | Disconnect pulse from the peripheral |
| par_err | input | 1 | Parity error detected on the current word |
| clr_io | input | 1 | Clear I/O |
| mclr | input | 1 | Master Clear |
| activate | input | 1 | Channel-activate command |
| at_limit | input | 1 | Current address equals limit address |
| mem_ack | input | 1 | Memory reference completed |
| flag_clr | input | 1 | Explicit channel-error flag clear |
| mem_req | output | 1 | One-cycle memory reference request |
| irq | output | 1 | One-cycle end-of-transfer interrupt request |
| active | output | 1 | Channel active state |
| chan_err | output | 1 | Channel-error flag |
| par_fault | output | 1 | Saved parity-fault flag |
| held_rdy | output | 1 | Held-ready latch |
| ref_pend | output | 1 | Memory reference outstanding |

## Verification
A wrong internal state appears at the ports one edge after the stimulus, because every state bit and both pulses are registered. A lost held ready appears as a missing request one edge after activation. A parity fault promoted too early appears as the channel-error flag rising on the fault edge instead of at transfer end. A termination that leaves the channel active appears as a second interrupt on a later disconnect. The sweep covers every combination of active state, saved fault, limit compare, ready and disconnect in one stimulus cycle.

// File: rtl/dma_in_pkg.sv
package dma_in_pkg;

    typedef enum logic [1:0] {
        RDY_NONE   = 2'd0,
        RDY_HOLD   = 2'd1,
        RDY_TAKE   = 2'd2,
        RDY_DOUBLE = 2'd3
    } rdy_kind_e;

    typedef struct packed {
        logic par_fault;
        logic chan_err;
    } err_flags_s;

    // Decide what an incoming ready pulse means in the current state.
    function automatic rdy_kind_e classify_ready(
        input logic ready,
        input logic active,
        input logic at_limit,
        input logic busy
    );
        rdy_kind_e k;
        if (!ready)                  k = RDY_NONE;
        else if (!active)            k = RDY_HOLD;
        else if (at_limit || busy)   k = RDY_DOUBLE;
        else                         k = RDY_TAKE;
        return k;
    endfunction

endpackage

// File: rtl/dma_in_ready_path.sv
module dma_in_ready_path
    import dma_in_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mclr,
    input  logic in_ready,
    input  logic at_limit,
    input  logic mem_ack,
    input  logic active,
    output logic double_rdy,
    output logic mem_req,
    output logic ref_pend,
    output logic held_rdy
);
    rdy_kind_e kind;
    logic      consume;
    logic      req_d;

    always_comb begin
        kind       = classify_ready(in_ready, active, at_limit, ref_pend | held_rdy);
        double_rdy = (kind == RDY_DOUBLE);
        consume    = held_rdy && active && !at_limit && !ref_pend && !in_ready;
        req_d      = (kind == RDY_TAKE) || consume;
    end

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            mem_req  <= 1'b0;
            ref_pend <= 1'b0;
            held_rdy <= 1'b0;
        end else begin
            mem_req <= req_d;
            if (req_d)        ref_pend <= 1'b1;
            else if (mem_ack) ref_pend <= 1'b0;
            if (consume)               held_rdy <= 1'b0;
            else if (kind == RDY_HOLD) held_rdy <= 1'b1;
        end
    end
endmodule

// File: rtl/dma_in_term.sv
module dma_in_term (
    input  logic clk,
    input  logic rst,
    input  logic mclr,
    input  logic activate,
    input  logic in_disc,
    input  logic at_limit,
    output logic term,
    output logic active,
    output logic irq
);
    always_comb term = active && (at_limit || in_disc);

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            active <= 1'b0;
            irq    <= 1'b0;
        end else begin
            irq <= term;
            if (active) active <= !term;
            else        active <= activate;
        end
    end
endmodule

// File: rtl/dma_in_flags.sv
module dma_in_flags
    import dma_in_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mclr,
    input  logic       clr_io,
    input  logic       flag_clr,
    input  logic       par_err,
    input  logic       double_rdy,
    input  logic       term,
    output err_flags_s flags
);
    logic err_set;

    always_comb err_set = double_rdy || (term && flags.par_fault);

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            flags <= '0;
        end else begin
            if (clr_io)       flags.par_fault <= 1'b0;
            else if (par_err) flags.par_fault <= 1'b1;
            if (clr_io || flag_clr) flags.chan_err <= 1'b0;
            else if (err_set)       flags.chan_err <= 1'b1;
        end
    end
endmodule

// File: rtl/dma_in_chan_ctl.sv
module dma_in_chan_ctl
    import dma_in_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_ready,
    input  logic in_disc,
    input  logic par_err,
    input  logic clr_io,
    input  logic mclr,
    input  logic activate,
    input  logic at_limit,
    input  logic mem_ack,
    input  logic flag_clr,
    output logic mem_req,
    output logic irq,
    output logic active,
    output logic chan_err,
    output logic par_fault,
    output logic held_rdy,
    output logic ref_pend
);
    logic       term;
    logic       double_rdy;
    err_flags_s flags;

    dma_in_term u_term (
        .clk(clk), .rst(rst), .mclr(mclr), .activate(activate),
        .in_disc(in_disc), .at_limit(at_limit),
        .term(term), .active(active), .irq(irq)
    );

    dma_in_ready_path u_ready (
        .clk(clk), .rst(rst), .mclr(mclr), .in_ready(in_ready),
        .at_limit(at_limit), .mem_ack(mem_ack), .active(active),
        .double_rdy(double_rdy), .mem_req(mem_req),
        .ref_pend(ref_pend), .held_rdy(held_rdy)
    );

    dma_in_flags u_flags (
        .clk(clk), .rst(rst), .mclr(mclr), .clr_io(clr_io),
        .flag_clr(flag_clr), .par_err(par_err),
        .double_rdy(double_rdy), .term(term), .flags(flags)
    );

    assign chan_err  = flags.chan_err;
    assign par_fault = flags.par_fault;
endmodule

// File: rtl/dma_in_chan_ctl_chk.sv
module dma_in_chan_ctl_chk (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic in_disc,
    input logic par_err,
    input logic clr_io,
    input logic mclr,
    input logic activate,
    input logic at_limit,
    input logic mem_ack,
    input logic flag_clr,
    input logic mem_req,
    input logic irq,
    input logic active,
    input logic chan_err,
    input logic par_fault,
    input logic held_rdy,
    input logic ref_pend
);
    // R1
    par_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(par_fault) |-> !$rose(chan_err) && !irq);

    // R2
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(active) && ($past(in_disc) || $past(at_limit)));

    // R3
    clrio_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr_io) && !$past(mclr) |-> !par_fault && !chan_err && active == $past(active));

    // R6
    fall_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) && !$past(mclr) |-> irq);

    // R7
    idle_irq_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(active) |-> !irq);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(chan_err) |-> $past(in_ready) || $past(par_fault));

    // R9
    req_active_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> $past(active) && ref_pend);

    // R10
    mclr_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mclr) |-> !active && !held_rdy && !ref_pend && !chan_err && !par_fault);

    // R12
    act_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(activate));

    // R11
    flagclr_chk: assert property (@(posedge clk) disable iff (rst)
        $past(flag_clr) |-> !chan_err);

    // R4
    held_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(held_rdy) |-> $past(in_ready) && !$past(active));

    // R9
    pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_pend) && !$past(mclr) |-> $past(mem_ack));

    // mem_ack and par_err feed only the pending and fault flags checked above
    logic unused_ok;
    always_comb unused_ok = ^{mem_ack, par_err};
endmodule

bind dma_in_chan_ctl dma_in_chan_ctl_chk u_chk (.*);

// File: tb/test_dma_in_chan_ctl.sv
module test_dma_in_chan_ctl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_ready = 0, in_disc = 0, par_err = 0, clr_io = 0, mclr = 0;
    logic activate = 0, at_limit = 0, mem_ack = 0, flag_clr = 0;
    logic mem_req, irq, active, chan_err, par_fault, held_rdy, ref_pend;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dma_in_chan_ctl i_dma_in_chan_ctl (.*);

    task automatic check(input string req, input string what, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // one stimulus cycle: drive at negedge, sample 2 ns after the posedge
    task automatic cyc(input logic r = 0, input logic d = 0, input logic p = 0,
                       input logic ci = 0, input logic mc = 0, input logic ac = 0,
                       input logic lim = 0, input logic ak = 0, input logic fc = 0);
        @(negedge clk);
        in_ready = r; in_disc = d; par_err = p; clr_io = ci; mclr = mc;
        activate = ac; at_limit = lim; mem_ack = ak; flag_clr = fc;
        @(posedge clk);
        #2;
    endtask

    function automatic int outv();
        return {irq, mem_req, active, chan_err, held_rdy, par_fault, ref_pend};
    endfunction

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        cyc();
        check("R10", "reset state", outv(), 0);

        // parity deferred to disconnect
        cyc(.ac(1));
        check("R12", "active after activate", active, 1);
        cyc(.p(1));
        check("R1", "fault saved", par_fault, 1);
        check("R1", "no error/irq", {chan_err, irq}, 0);
        cyc(.r(1));
        check("R9", "request+pending", {mem_req, ref_pend}, 3);
        cyc(.ak(1));
        check("R9", "ack clears pending", {mem_req, ref_pend}, 0);
        cyc(.d(1));
        check("R2", "disc irq/inactive/err", {irq, active, chan_err}, 3'b101);
        cyc();
        check("R2", "irq one cycle", irq, 0);
        cyc(.d(1));
        check("R7", "disc while inactive", irq, 0);

        // clear I/O
        cyc(.ci(1));
        check("R3", "clears flags, stays inactive", {par_fault, chan_err, active}, 0);
        cyc(.ac(1));
        cyc(.p(1));
        cyc(.ci(1));
        check("R3", "active kept, fault cleared", {active, par_fault}, 2'b10);

        // double ready and flag clear
        cyc(.r(1));
        check("R9", "request", mem_req, 1);
        cyc(.r(1));
        check("R8", "double ready while pending", {chan_err, mem_req}, 2'b10);
        cyc(.fc(1));
        check("R11", "flag clear", chan_err, 0);
        cyc(.r(1), .fc(1));
        check("R11", "clear beats set", chan_err, 0);
        cyc(.ak(1));

        // limit termination
        cyc(.p(1));
        cyc(.lim(1));
        check("R6", "limit irq/inactive/err", {irq, active, chan_err}, 3'b101);
        cyc(.d(1));
        check("R7", "late disc ignored", irq, 0);

        // held ready
        cyc(.ci(1), .mc(1));
        check("R10", "master clear", outv(), 0);
        cyc(.r(1), .lim(1));
        check("R4", "held at limit, no err", {held_rdy, chan_err, irq, mem_req}, 4'b1000);
        cyc(); cyc(); cyc();
        check("R4", "still held", held_rdy, 1);
        cyc(.ac(1));
        check("R5", "not yet consumed", {active, mem_req, held_rdy}, 3'b101);
        cyc();
        check("R5", "consumed", {mem_req, held_rdy, ref_pend}, 3'b101);
        cyc(.ak(1));
        cyc(.r(1));
        cyc(.p(1));
        cyc(.r(1));
        check("R8", "double ready", chan_err, 1);
        cyc(.mc(1), .ci(1));
        check("R10", "master clear all", outv(), 0);
        cyc(.r(1));
        cyc(.mc(1), .ci(1));
        check("R10", "held cleared", held_rdy, 0);

        // sweep of one stimulus cycle over state and inputs
        for (int v = 0; v < 32; v++) begin
            logic a, pf, lim, r, d, tm;
            int exp;
            {a, pf, lim, r, d} = v[4:0];
            cyc(.mc(1), .ci(1));
            if (pf) cyc(.p(1));
            if (a)  cyc(.ac(1));
            cyc(.r(r), .d(d), .lim(lim));
            tm  = a && (lim || d);
            exp = {tm, a && r && !lim, a && !tm, (r && a && lim) || (tm && pf),
                   r && !a, pf, a && r && !lim};
            check(a ? (tm ? "R6" : "R9") : "R4", $sformatf("sweep %0d", v), outv(), exp);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule